// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Sequencer

This block is the bit-level master for an open-drain single-wire bus. It runs from the system clock and is paced by a one-microsecond tick enable. A host asks it for one of four operations: a bus reset with presence detection, a 0 bit written, a 1 bit written, or a bit read. The block then pulls the line low through an output enable for the right number of ticks, releases it, and samples the resynchronised line input where the operation needs it. When the operation is over it pulses a done strobe and updates either its presence flag or its received bit.

Every phase length is a parameter counted in ticks: the low and high halves of a reset, the write-0 low time, the short low that opens a write-1 or read slot, the total slot length and the recovery gap. Presence is not taken from a single sample. The released line has to read high at an early check point, and it then has to go low somewhere inside a window that opens and closes at set tick counts after the release. A master that is busy ignores new requests, so a new request is taken only when the master is idle.

Top module: `onewire_master`

## Requirements
- R1: While reset is high and in the first cycle after it, line_oe=0, cmd_ready=1, done=0, presence=0 and rx_bit=0.
- R2: Operation code 2'b00 (bus reset) drives the line low for exactly RST_LOW ticks (default 500) and then leaves it released for exactly RST_HIGH ticks (default 500) before done.
- R3: After a bus reset, presence=1 when the line read high at released tick PRES_CHK (default 2) and read low at some released tick from PRES_OPEN to PRES_CLOSE (defaults 15 to 120).
- R4: After a bus reset, presence=0 when no device pulls the line low, or when the pull-down starts only after PRES_CLOSE.
- R5: After a bus reset, presence=0 when the line is already low at the released check tick, even if it is also low inside the window.
- R6: Operation code 2'b01 (write 0) drives the line low for exactly W0_LOW ticks (default 100). The line then stays released for SLOT-W0_LOW+REC ticks (SLOT=120, REC=2) before done.
- R7: Operation code 2'b10 (write 1) drives the line low for exactly SHORT_LOW ticks (default 5). The line then stays released for SLOT-SHORT_LOW+REC ticks before done.
- R8: Operation code 2'b11 (read) has the same line timing as write 1. At its done, rx_bit takes the line level that was sampled at tick SAMPLE_AT (default 13) of the slot.
- R9: Between the end of one operation's low phase and the start of the next operation's low phase, the line stays released for at least that operation's release length. This holds even when the next request is already waiting.
- R10: cmd_ready is 0 while an operation is in progress. A request raised in that time starts no operation and produces no done.
- R11: done is a single-cycle pulse. presence changes only at the done of a bus reset, and rx_bit changes only at the done of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle enable, once per microsecond |
| cmd_valid | input | 1 | Operation request |
| cmd_op | input | 2 | Operation code: 00 reset, 01 write 0, 10 write 1, 11 read |
| cmd_ready | output | 1 | Master idle; a request is taken in this cycle |
| line_in | input | 1 | Bus line level (asynchronous) |
| line_oe | output | 1 | 1 pulls the bus line low |
| done | output | 1 | One-cycle end-of-operation strobe |
| presence | output | 1 | Presence result of the last bus reset |
| rx_bit | output | 1 | Bit received in the last read slot |

## Verification
Two things can happen in the same clock cycle: the done of one operation and the acceptance of the next request. A queued request therefore starts its low phase right after a result is published. The bench provokes this by raising the next request while the current slot is still running, so the request is taken in the very cycle done is high. It then judges that the finished result is correct, that the released gap before the new low phase still covers the slot tail and the recovery, and that the scoreboard receives exactly one done for each request.

// File: rtl/owm_pkg.sv
package owm_pkg;

  // Operation codes as they appear on cmd_op
  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_WR0   = 2'b01,
    OP_WR1   = 2'b10,
    OP_READ  = 2'b11
  } owm_op_e;

  // Sequencer phases
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOW   = 2'd1,
    ST_HIGH  = 2'd2,
    ST_RECOV = 2'd3
  } owm_state_e;

endpackage

// File: rtl/owm_sync.sv
// Multi-stage resynchroniser for the bus line; resets to the released level.
module owm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/owm_tick_timer.sv
// Phase timer: counts microsecond ticks, flags the tick that ends the phase.
module owm_tick_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] count,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (tick)    count <= count + 1'b1;
  end

  assign last = tick && (count == limit - 1'b1);
endmodule

// File: rtl/owm_presence_win.sv
// Presence qualifier: line must be high at the check tick and low
// somewhere inside [WOPEN, WCLOSE] released ticks.
module owm_presence_win #(
  parameter int CW     = 10,
  parameter int PCHK   = 2,
  parameter int WOPEN  = 15,
  parameter int WCLOSE = 120
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          en,
  input  logic [CW-1:0] count,
  input  logic          line_s,
  output logic          found
);
  localparam logic [CW-1:0] T_CHK   = CW'(PCHK);
  localparam logic [CW-1:0] T_OPEN  = CW'(WOPEN);
  localparam logic [CW-1:0] T_CLOSE = CW'(WCLOSE);

  logic seen_q, stuck_q;

  always_ff @(posedge clk) begin
    if (rst || arm) begin
      seen_q  <= 1'b0;
      stuck_q <= 1'b0;
    end else if (en) begin
      if (count == T_CHK && !line_s)
        stuck_q <= 1'b1;
      if (count >= T_OPEN && count <= T_CLOSE && !line_s)
        seen_q <= 1'b1;
    end
  end

  assign found = seen_q && !stuck_q;
endmodule

// File: rtl/onewire_master.sv
module onewire_master
  import owm_pkg::*;
#(
  parameter int RST_LOW    = 500,
  parameter int RST_HIGH   = 500,
  parameter int W0_LOW     = 100,
  parameter int SHORT_LOW  = 5,
  parameter int SLOT       = 120,
  parameter int REC        = 2,
  parameter int SAMPLE_AT  = 13,
  parameter int PRES_CHK   = 2,
  parameter int PRES_OPEN  = 15,
  parameter int PRES_CLOSE = 120,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       us_tick,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  output logic       cmd_ready,
  input  logic       line_in,
  output logic       line_oe,
  output logic       done,
  output logic       presence,
  output logic       rx_bit
);

  // Counter wide enough for the longest phase plus headroom
  localparam int CW = $clog2(RST_LOW + RST_HIGH + SLOT + REC + 1) + 1;

  localparam logic [CW-1:0] T_RST_LOW  = CW'(RST_LOW);
  localparam logic [CW-1:0] T_RST_HIGH = CW'(RST_HIGH);
  localparam logic [CW-1:0] T_W0_LOW   = CW'(W0_LOW);
  localparam logic [CW-1:0] T_SH_LOW   = CW'(SHORT_LOW);
  localparam logic [CW-1:0] T_W0_HIGH  = CW'(SLOT - W0_LOW);
  localparam logic [CW-1:0] T_SH_HIGH  = CW'(SLOT - SHORT_LOW);
  localparam logic [CW-1:0] T_REC      = CW'(REC);
  // released-phase count value at which the read sample is taken
  localparam logic [CW-1:0] T_RD_IDX   = CW'(SAMPLE_AT - SHORT_LOW - 1);

  owm_state_e    state_q;
  owm_op_e       op_q;
  logic          line_s;
  logic          accept;
  logic          tmr_tick;
  logic          tmr_clear;
  logic          tmr_last;
  logic [CW-1:0] tmr_count;
  logic [CW-1:0] tmr_limit;
  logic          pres_arm;
  logic          pres_en;
  logic          pres_found;
  logic          rd_cap_q;

  // ---------------- line input resynchroniser ----------------
  owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (line_in),
    .q   (line_s)
  );

  // ---------------- request acceptance (busy has priority) ----------------
  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;

  // ---------------- phase length selection ----------------
  always_comb begin
    tmr_limit = T_REC;
    unique case (state_q)
      ST_LOW: begin
        if (op_q == OP_RESET)    tmr_limit = T_RST_LOW;
        else if (op_q == OP_WR0) tmr_limit = T_W0_LOW;
        else                     tmr_limit = T_SH_LOW;
      end
      ST_HIGH: begin
        if (op_q == OP_RESET)    tmr_limit = T_RST_HIGH;
        else if (op_q == OP_WR0) tmr_limit = T_W0_HIGH;
        else                     tmr_limit = T_SH_HIGH;
      end
      default: tmr_limit = T_REC;
    endcase
  end

  assign tmr_tick  = us_tick && (state_q != ST_IDLE);
  assign tmr_clear = accept || tmr_last;

  owm_tick_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clear (tmr_clear),
    .tick  (tmr_tick),
    .limit (tmr_limit),
    .count (tmr_count),
    .last  (tmr_last)
  );

  // ---------------- presence window ----------------
  assign pres_arm = accept && (cmd_op == OP_RESET);
  assign pres_en  = us_tick && (state_q == ST_HIGH) && (op_q == OP_RESET);

  owm_presence_win #(
    .CW     (CW),
    .PCHK   (PRES_CHK),
    .WOPEN  (PRES_OPEN),
    .WCLOSE (PRES_CLOSE)
  ) u_pres (
    .clk    (clk),
    .rst    (rst),
    .arm    (pres_arm),
    .en     (pres_en),
    .count  (tmr_count),
    .line_s (line_s),
    .found  (pres_found)
  );

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_RESET;
      line_oe  <= 1'b0;
      done     <= 1'b0;
      presence <= 1'b0;
      rx_bit   <= 1'b0;
      rd_cap_q <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            op_q    <= owm_op_e'(cmd_op);
            line_oe <= 1'b1;
            state_q <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (tmr_last) begin
            line_oe <= 1'b0;
            state_q <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (op_q == OP_READ && us_tick && tmr_count == T_RD_IDX)
            rd_cap_q <= line_s;
          if (tmr_last) begin
            if (op_q == OP_RESET) begin
              presence <= pres_found;
              done     <= 1'b1;
              state_q  <= ST_IDLE;
            end else begin
              state_q  <= ST_RECOV;
            end
          end
        end
        default: begin
          if (tmr_last) begin
            if (op_q == OP_READ) rx_bit <= rd_cap_q;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/owm_checks.sv
module owm_checks (
  input logic clk,
  input logic rst,
  input logic us_tick,
  input logic cmd_ready,
  input logic line_oe,
  input logic done,
  input logic presence,
  input logic rx_bit
);

  // R6: the low phase only ends on a microsecond tick
  p_low_ends_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(line_oe) |-> $past(us_tick));

  // R10: the line is only pulled after the master was idle
  p_start_from_idle_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(line_oe) |-> $past(cmd_ready));

  // R10: never ready while pulling the line
  p_busy_while_low_r10: assert property (@(posedge clk) disable iff (rst)
    line_oe |-> !cmd_ready);

  // R11: done lasts one cycle
  p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: results are published with the line released
  p_done_released_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !line_oe);

  // R3: presence moves only together with done
  p_presence_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(presence));

  // R8: received bit moves only together with done
  p_rxbit_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(rx_bit));

endmodule

bind onewire_master owm_checks u_owm_checks (
  .clk       (clk),
  .rst       (rst),
  .us_tick   (us_tick),
  .cmd_ready (cmd_ready),
  .line_oe   (line_oe),
  .done      (done),
  .presence  (presence),
  .rx_bit    (rx_bit)
);

// File: tb/onewire_master_tb_top.sv
module onewire_master_tb_top;
  import owm_pkg::*;

  localparam int RST_LOW   = 500;
  localparam int RST_HIGH  = 500;
  localparam int W0_LOW    = 100;
  localparam int SHORT_LOW = 5;
  localparam int SLOT      = 120;
  localparam int REC       = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       us_tick = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic       line_in;
  logic       cmd_ready, line_oe, done, presence, rx_bit;

  // bus device model controls
  logic dev_pull = 1'b0, dev_stuck = 1'b0, dev_pres_en = 1'b0, dev_rd0 = 1'b0;
  int   p_start = 0, p_len = 0;
  int   since_rise = 100000, since_fall = 100000;
  logic dev_oe_prev = 1'b0;

  assign line_in = ~(line_oe | dev_pull);

  onewire_master dut_i (
    .clk       (clk),
    .rst       (rst),
    .us_tick   (us_tick),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_ready (cmd_ready),
    .line_in   (line_in),
    .line_oe   (line_oe),
    .done      (done),
    .presence  (presence),
    .rx_bit    (rx_bit)
  );

  always #5 clk = ~clk;

  // tick enable every second cycle
  initial forever begin
    @(posedge clk);
    #1 us_tick = ~us_tick;
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  always @(negedge clk) begin
    if (line_oe && !dev_oe_prev)      since_rise = 0;
    else if (us_tick)                 since_rise++;
    if (!line_oe && dev_oe_prev)      since_fall = 0;
    else if (us_tick)                 since_fall++;
    dev_oe_prev = line_oe;
    dev_pull = dev_stuck
            || (dev_pres_en && !line_oe && since_fall >= p_start
                && since_fall < p_start + p_len)
            || (dev_rd0 && since_rise < 30);
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    int    low;
    int    rel;
    logic  pres;
    logic  rx;
    string tag;
  } item_t;

  item_t q[$];
  logic  m_pres = 1'b0, m_rx = 1'b0;

  task automatic send(input owm_op_e op, input logic exp_bit, input string tag);
    item_t it;
    case (op)
      OP_RESET: begin it.low = RST_LOW;   it.rel = RST_HIGH; m_pres = exp_bit; end
      OP_WR0:   begin it.low = W0_LOW;    it.rel = SLOT - W0_LOW + REC; end
      OP_WR1:   begin it.low = SHORT_LOW; it.rel = SLOT - SHORT_LOW + REC; end
      default:  begin it.low = SHORT_LOW; it.rel = SLOT - SHORT_LOW + REC; m_rx = exp_bit; end
    endcase
    it.pres = m_pres;
    it.rx   = m_rx;
    it.tag  = tag;
    q.push_back(it);
    @(posedge clk);
    #1 cmd_valid = 1'b1;
    cmd_op = op;
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (q.size() != 0 || !cmd_ready);
  endtask

  // monitor
  int   low_cnt = 0, low_last = 0, rel_cnt = 0, min_gap = 0;
  bit   have_prev = 0;
  logic mon_prev = 1'b0, done_prev = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (line_oe && !mon_prev) begin
        chk(!cmd_ready, "R10", "ready while pulling", int'(cmd_ready), 0);
        if (have_prev)
          chk(rel_cnt >= min_gap, "R9", "released ticks before next low", rel_cnt, min_gap);
        low_cnt = 0;
      end
      if (!line_oe && mon_prev) begin
        low_last = low_cnt;
        rel_cnt  = 0;
      end
      if (done) begin
        chk(!done_prev, "R11", "done longer than one cycle", 1, 0);
        if (q.size() == 0) begin
          chk(0, "R10", "done without request", 1, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          chk(low_last == it.low, it.tag, "low ticks", low_last, it.low);
          chk(rel_cnt == it.rel, it.tag, "released ticks", rel_cnt, it.rel);
          chk(presence == it.pres, it.tag, "presence", int'(presence), int'(it.pres));
          chk(rx_bit == it.rx, it.tag, "rx_bit", int'(rx_bit), int'(it.rx));
          min_gap   = it.rel;
          have_prev = 1;
        end
      end
      if (us_tick) begin
        if (line_oe) low_cnt++;
        else         rel_cnt++;
      end
      mon_prev  = line_oe;
      done_prev = done;
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WATCHDOG", "run did not complete", 0, 1);
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(!line_oe, "R1", "line_oe in reset", int'(line_oe), 0);
    chk(cmd_ready, "R1", "cmd_ready in reset", int'(cmd_ready), 1);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!line_oe && !done, "R1", "oe/done after reset", int'(line_oe | done), 0);
    chk(!presence && !rx_bit, "R1", "results after reset", int'(presence | rx_bit), 0);

    // bus reset with a well-placed presence pulse
    dev_pres_en = 1'b1; p_start = 20; p_len = 80;
    send(OP_RESET, 1'b1, "R2");
    wait_idle();
    // no device on the bus
    dev_pres_en = 1'b0;
    send(OP_RESET, 1'b0, "R4");
    wait_idle();
    // presence that starts late in the window
    dev_pres_en = 1'b1; p_start = 100; p_len = 100;
    send(OP_RESET, 1'b1, "R3");
    wait_idle();
    // pull-down after the window has closed
    p_start = 150; p_len = 60;
    send(OP_RESET, 1'b0, "R4");
    wait_idle();
    // line stuck low at release
    dev_pres_en = 1'b0; dev_stuck = 1'b1;
    send(OP_RESET, 1'b0, "R5");
    wait_idle();
    dev_stuck = 1'b0;
    repeat (10) @(posedge clk);
    // restore presence, then slots must leave it alone
    dev_pres_en = 1'b1; p_start = 40; p_len = 100;
    send(OP_RESET, 1'b1, "R3");
    wait_idle();
    dev_pres_en = 1'b0;

    send(OP_WR0, 1'b0, "R6");
    wait_idle();
    send(OP_WR1, 1'b0, "R7");
    wait_idle();
    dev_rd0 = 1'b0;
    send(OP_READ, 1'b1, "R8");
    wait_idle();
    dev_rd0 = 1'b1;
    send(OP_READ, 1'b0, "R8");
    wait_idle();
    dev_rd0 = 1'b0;
    send(OP_WR1, 1'b0, "R11");
    wait_idle();

    // back-to-back requests: next one waits through done
    send(OP_WR1, 1'b0, "R9");
    send(OP_WR0, 1'b0, "R9");
    send(OP_READ, 1'b1, "R9");
    send(OP_WR0, 1'b0, "R9");
    wait_idle();

    // request raised while busy must be ignored
    send(OP_WR0, 1'b0, "R10");
    repeat (20) @(posedge clk);
    #1 cmd_valid = 1'b1;
    cmd_op = OP_READ;
    repeat (6) @(posedge clk);
    #1 cmd_valid = 1'b0;
    wait_idle();
    repeat (400) @(negedge clk);
    chk(!line_oe && cmd_ready, "R10", "ignored request started a slot",
        int'(line_oe), 0);
    chk(q.size() == 0, "R10", "pending scoreboard items", q.size(), 0);

    finish_run();
  end

endmodule